// File: doc/BRIEF.md
# Write-First Bypassing Register File

A small register file for a five-stage in-order pipeline. It has one synchronous write port and two combinational read ports. A result that the write-back stage commits in a given cycle can be read by the decode stage in that same cycle. A register file without this bypass makes decode wait one more cycle for the stored copy. Here the write data is steered onto any read port whose address matches the write in progress, while the array itself loads on the rising clock edge.

Each read port makes its own choice of data source every cycle, and that choice is named by an enumerated selector:

- `RDSRC_OFF`: the port is disabled and drives zero.
- `RDSRC_BYPASS`: an enabled write to the same register is in flight, so the port drives the incoming write data.
- `RDSRC_ARRAY`: the port drives the stored register contents.

The selector holds no state. It moves between these three values freely from cycle to cycle as the enables and addresses change. It reaches OFF when its read enable is low, BYPASS when the enabled write address equals the read address, and ARRAY otherwise. An active-low reset clears every register to zero. The default size is four registers of 32 bits.

Top module: `wf_regfile`

## Requirements
- R1: While reset is held and right after it is released, every register reads as zero on both read ports.
- R2: With `wr_en` high at a rising clock edge, `wr_data` is stored at `wr_addr`. Later reads of that register return it until it is written again.
- R3: When `wr_en` is high and an enabled read port's address equals `wr_addr`, that port outputs `wr_data` in the same cycle, before the clock edge.
- R4: A read of a register other than the one being written returns the stored contents, not the write data.
- R5: With `wr_en` low, neither the stored contents nor the read outputs are affected by `wr_addr` or `wr_data`, even when the addresses match.
- R6: A read port whose enable is low drives all zeros, including when its address matches an enabled write.
- R7: The two read ports are independent. They may read different registers, or both the same register, including both being bypassed from one write.
- R8: Read outputs are combinational. A change of read address or enable is reflected on the output without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the array loads on the rising edge |
| rst_n | input | 1 | Active-low asynchronous clear of all registers |
| wr_en | input | 1 | Write enable |
| wr_addr | input | ADDR_W (2) | Register written |
| wr_data | input | DATA_W (32) | Data written |
| rd0_en | input | 1 | Read port 0 enable |
| rd0_addr | input | ADDR_W (2) | Read port 0 register select |
| rd0_data | output | DATA_W (32) | Read port 0 data |
| rd1_en | input | 1 | Read port 1 enable |
| rd1_addr | input | ADDR_W (2) | Read port 1 register select |
| rd1_data | output | DATA_W (32) | Read port 1 data |

## Verification
The two functions that share a cycle are the write into the array and a read of the same register. This collision is provoked by driving an enabled write and a matching read address together in the low clock phase. The read output is judged before the edge against the new data rather than the stored value, and judged again after the edge against the stored copy. The same collision is repeated with the write enable low, and again with the read enable low, to show that the bypass needs both. Reads of a register other than the one being written run in the same cycle as a write to confirm they still return the old contents.

// File: rtl/wf_regfile_pkg.sv
package wf_regfile_pkg;

    localparam int DEF_ADDR_W = 2;
    localparam int DEF_DATA_W = 32;
    localparam int NUM_RD     = 2;

    // Source chosen by a read port in the current cycle.
    typedef enum logic [1:0] {
        RDSRC_OFF    = 2'd0,
        RDSRC_BYPASS = 2'd1,
        RDSRC_ARRAY  = 2'd2
    } rd_src_e;

endpackage

// File: rtl/wf_rf_storage.sv
module wf_rf_storage #(
    parameter int ADDR_W = wf_regfile_pkg::DEF_ADDR_W,
    parameter int DATA_W = wf_regfile_pkg::DEF_DATA_W,
    localparam int NREG  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] regs_q [NREG]
);

    // One load strobe per register, decoded from the write address.
    logic [NREG-1:0] load;

    always_comb begin
        load = '0;
        if (wr_en) begin
            load[wr_addr] = 1'b1;
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[g] <= '0;
            end else if (load[g]) begin
                regs_q[g] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/wf_rf_read_port.sv
module wf_rf_read_port #(
    parameter int ADDR_W = wf_regfile_pkg::DEF_ADDR_W,
    parameter int DATA_W = wf_regfile_pkg::DEF_DATA_W,
    localparam int NREG  = 1 << ADDR_W
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] regs_q [NREG],
    output logic [DATA_W-1:0] rd_data
);
    import wf_regfile_pkg::*;

    rd_src_e src;

    // Source selection: disabled port wins, then an in-flight matching write.
    always_comb begin
        if (!rd_en) begin
            src = RDSRC_OFF;
        end else if (wr_en && (wr_addr == rd_addr)) begin
            src = RDSRC_BYPASS;
        end else begin
            src = RDSRC_ARRAY;
        end
    end

    always_comb begin
        unique case (src)
            RDSRC_OFF:    rd_data = '0;
            RDSRC_BYPASS: rd_data = wr_data;
            RDSRC_ARRAY:  rd_data = regs_q[rd_addr];
            default:      rd_data = '0;
        endcase
    end

endmodule

// File: rtl/wf_regfile.sv
module wf_regfile #(
    parameter int ADDR_W = wf_regfile_pkg::DEF_ADDR_W,
    parameter int DATA_W = wf_regfile_pkg::DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd0_en,
    input  logic [ADDR_W-1:0] rd0_addr,
    output logic [DATA_W-1:0] rd0_data,
    input  logic              rd1_en,
    input  logic [ADDR_W-1:0] rd1_addr,
    output logic [DATA_W-1:0] rd1_data
);
    import wf_regfile_pkg::*;

    localparam int NREG = 1 << ADDR_W;

    logic [DATA_W-1:0] regs_q  [NREG];
    logic [NUM_RD-1:0] rp_en;
    logic [ADDR_W-1:0] rp_addr [NUM_RD];
    logic [DATA_W-1:0] rp_data [NUM_RD];

    assign rp_en[0]   = rd0_en;
    assign rp_en[1]   = rd1_en;
    assign rp_addr[0] = rd0_addr;
    assign rp_addr[1] = rd1_addr;
    assign rd0_data   = rp_data[0];
    assign rd1_data   = rp_data[1];

    wf_rf_storage #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .regs_q  (regs_q)
    );

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        wf_rf_read_port #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W)
        ) u_port (
            .rd_en   (rp_en[p]),
            .rd_addr (rp_addr[p]),
            .wr_en   (wr_en),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .regs_q  (regs_q),
            .rd_data (rp_data[p])
        );
    end

endmodule

// File: rtl/wf_regfile_chk.sv
module wf_regfile_chk #(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd0_en,
    input logic [ADDR_W-1:0] rd0_addr,
    input logic [DATA_W-1:0] rd0_data,
    input logic              rd1_en,
    input logic [ADDR_W-1:0] rd1_addr,
    input logic [DATA_W-1:0] rd1_data
);

    AST_BYPASS_P0: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd0_en && rd0_addr == wr_addr) |-> rd0_data == wr_data); // R3

    AST_BYPASS_P1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd1_en && rd1_addr == wr_addr) |-> rd1_data == wr_data); // R3

    AST_OFF_ZERO_P0: assert property (@(posedge clk) disable iff (!rst_n)
        !rd0_en |-> rd0_data == '0); // R6

    AST_OFF_ZERO_P1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd1_en |-> rd1_data == '0); // R6

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && $past(wr_addr) == rd0_addr && rd0_en
         && !(wr_en && wr_addr == rd0_addr)) |-> rd0_data == $past(wr_data)); // R2

    AST_IDLE_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en) && $past(rd0_en) && rd0_en
         && $past(rd0_addr) == rd0_addr && !(wr_en && wr_addr == rd0_addr))
        |-> $stable(rd0_data)); // R5

endmodule

bind wf_regfile wf_regfile_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd0_en   (rd0_en),
    .rd0_addr (rd0_addr),
    .rd0_data (rd0_data),
    .rd1_en   (rd1_en),
    .rd1_addr (rd1_addr),
    .rd1_data (rd1_data)
);

// File: tb/wf_regfile_tb.sv
`timescale 1ns/100ps
module wf_regfile_tb;

    localparam int AW = 2;
    localparam int DW = 32;
    localparam int NR = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          rd0_en = 1'b0;
    logic [AW-1:0] rd0_addr = '0;
    logic [DW-1:0] rd0_data;
    logic          rd1_en = 1'b0;
    logic [AW-1:0] rd1_addr = '0;
    logic [DW-1:0] rd1_data;

    logic [DW-1:0] model [NR];
    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    wf_regfile #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd0_en(rd0_en), .rd0_addr(rd0_addr), .rd0_data(rd0_data),
        .rd1_en(rd1_en), .rd1_addr(rd1_addr), .rd1_data(rd1_data)
    );

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 1'b0; rd0_en = 1'b0; rd1_en = 1'b0;
    endtask

    task automatic write_reg(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        model[a] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // R1: cleared contents during and after reset
    task automatic t_reset();
        for (int i = 0; i < NR; i++) model[i] = '0;
        rd0_en = 1'b1; rd1_en = 1'b1;
        for (int a = 0; a < NR; a++) begin
            rd0_addr = AW'(a); rd1_addr = AW'(a);
            #0.4;
            chk("R1 port0 in reset", rd0_data, '0);
            chk("R1 port1 in reset", rd1_data, '0);
        end
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        for (int a = 0; a < NR; a++) begin
            rd0_addr = AW'(a); #0.4;
            chk("R1 after release", rd0_data, '0);
        end
        idle();
    endtask

    // R2, R7: write every register, read back on both ports
    task automatic t_write_read();
        for (int a = 0; a < NR; a++) write_reg(AW'(a), 32'hA000_0000 + 32'(a * 17));
        @(negedge clk);
        rd0_en = 1'b1; rd1_en = 1'b1;
        for (int a = 0; a < NR; a++) begin
            rd0_addr = AW'(a); rd1_addr = AW'(NR - 1 - a);
            #0.4;
            chk("R2 port0 readback", rd0_data, model[a]);
            chk("R7 port1 other reg", rd1_data, model[NR - 1 - a]);
        end
        idle();
    endtask

    // R3, R7: same-cycle write and read of one register on both ports
    task automatic t_bypass();
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 32'hB1A5_5ED0;
        rd0_en = 1'b1; rd0_addr = 2'd2;
        rd1_en = 1'b1; rd1_addr = 2'd2;
        #0.4;
        chk("R3 port0 same-cycle", rd0_data, 32'hB1A5_5ED0);
        chk("R7 port1 same-cycle", rd1_data, 32'hB1A5_5ED0);
        @(posedge clk); model[2] = 32'hB1A5_5ED0;
        @(negedge clk); wr_en = 1'b0; #0.4;
        chk("R3 stored after edge", rd0_data, model[2]);
        idle();
    endtask

    // R4: read other registers while one is written
    task automatic t_diff_addr();
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = 32'h1234_5678;
        rd0_en = 1'b1; rd0_addr = 2'd3;
        rd1_en = 1'b1; rd1_addr = 2'd0;
        #0.4;
        chk("R4 port0 old value", rd0_data, model[3]);
        chk("R4 port1 old value", rd1_data, model[0]);
        @(posedge clk); model[1] = 32'h1234_5678;
        @(negedge clk); wr_en = 1'b0; rd0_addr = 2'd1; #0.4;
        chk("R4 written reg updated", rd0_data, model[1]);
        idle();
    endtask

    // R5: disabled write to a matching address
    task automatic t_disabled_write();
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 2'd0; wr_data = 32'hDEAD_BEEF;
        rd0_en = 1'b1; rd0_addr = 2'd0;
        #0.4;
        chk("R5 no bypass", rd0_data, model[0]);
        @(posedge clk);
        @(negedge clk); #0.4;
        chk("R5 no store", rd0_data, model[0]);
        idle();
    endtask

    // R6: disabled read port drives zero even on a bypass match
    task automatic t_read_off();
        @(negedge clk);
        rd0_en = 1'b0; rd0_addr = 2'd3;
        #0.4;
        chk("R6 off stored reg", rd0_data, '0);
        wr_en = 1'b1; wr_addr = 2'd3; wr_data = 32'h0F0F_7777;
        rd1_en = 1'b1; rd1_addr = 2'd3;
        #0.4;
        chk("R6 off with bypass", rd0_data, '0);
        chk("R7 other port bypassed", rd1_data, 32'h0F0F_7777);
        @(posedge clk); model[3] = 32'h0F0F_7777;
        @(negedge clk); wr_en = 1'b0;
        idle();
    endtask

    // R8: outputs follow address and enable changes inside one low phase
    task automatic t_combinational();
        @(negedge clk);
        rd0_en = 1'b1;
        for (int a = 0; a < NR; a++) begin
            rd0_addr = AW'(a); #0.4;
            chk("R8 address change", rd0_data, model[a]);
        end
        rd0_en = 1'b0; #0.3;
        chk("R8 enable drop", rd0_data, '0);
        idle();
    endtask

    initial begin
        t_reset();
        t_write_read();
        t_bypass();
        t_diff_addr();
        t_disabled_write();
        t_read_off();
        t_combinational();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule